// File: doc/BRIEF.md
# Byte-Lane Masked Asynchronous RAM Data Port

This block models the data side of a 16-bit asynchronous static-style RAM whose two byte lanes each have their own active-low enable. An external master drives a chip select, a write strobe, two lane enables, an address and a data word with no clock relationship. The block oversamples all of these on its own system clock, keeps a small word array, and answers as the real port would: a read presents only the lanes that are enabled and marks the others as undriven, and a write changes only the enabled lanes of the addressed word.

A write cycle is open while chip select and write strobe are both low and at least one lane enable is low. It ends at the first rising edge among chip select, write strobe and the lane enables that took part. The address and data sampled just before that edge are stored. Later changes to the bus or to the strobes that are still low do not change the stored word. The data port is given as a 16-bit output value plus one drive-enable bit per lane, so that a tri-state pad or bus model can be attached at the chip level.

Top module: `lane_masked_ram`

## Requirements
- R1: After reset both lane drive enables (`dq_oe`) are 0.
- R2: A read (chip select low, write strobe high, both lane enables low) drives both lanes with the word stored at the address. The output settles within two clock cycles of the inputs and stays valid while they are held.
- R3: A read with only one lane enable low sets only that lane's drive bit (`dq_oe[0]` for the low lane enable, `dq_oe[1]` for the high one) and presents that lane's stored byte. The other lane is not driven.
- R4: With chip select low and both lane enables high, no lane is driven and no byte of the array changes.
- R5: A write stores `din[7:0]` only if the low lane enable was low, and `din[15:8]` only if the high lane enable was low. A lane that was not enabled keeps its previous byte.
- R6: While chip select is high, no write takes place and no lane is driven, whatever the other strobes do.
- R7: The stored address and data are those sampled just before the first rising edge of chip select, write strobe or an enabled lane enable. Address or data changes after that edge are ignored.
- R8: Each write cycle commits exactly once. If one lane enable rises while the other is still low, both enabled lanes take the data from before the first rise, and the later rise writes nothing.
- R9: The word index is the address modulo `DEPTH` (`DEPTH` is a power of two). Addresses beyond the array alias onto it.
- R10: While a write cycle is open, no lane is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| lo_en_n | input | 1 | Low byte lane enable (bits 7:0), active low |
| hi_en_n | input | 1 | High byte lane enable (bits 15:8), active low |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data from the master |
| dq_o | output | 16 | Read data value |
| dq_oe | output | 2 | Per-lane drive enable, bit 0 low lane, bit 1 high lane |

## Verification
The bench builds the block with `DEPTH` = 16 and a 6-bit address. Every array word can therefore be written and read back in a few hundred cycles, and each word is reached through four aliasing addresses, which exercises the modulo wrap. Every word is written under every lane-enable combination and every way of ending the cycle: chip select rising, write strobe rising, the lane enables rising together, or the two lane enables rising one after the other. The expected contents come from a byte-masked model in the bench.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic             cs_n;
        logic             wr_n;
        logic [LANES-1:0] be_n;
    } strobe_t;

    function automatic logic is_write(input strobe_t s);
        return !s.cs_n && !s.wr_n && (s.be_n != {LANES{1'b1}});
    endfunction

    function automatic logic is_read(input strobe_t s);
        return !s.cs_n && s.wr_n;
    endfunction
endpackage

// File: rtl/lmr_sampler.sv
module lmr_sampler
    import lmr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           strobe_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output strobe_t           cur_st,
    output strobe_t           prev_st,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [IDX_W-1:0]  prev_idx,
    output logic [DATA_W-1:0] prev_data
);
    typedef struct packed {
        strobe_t           st;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } sample_t;

    typedef struct packed {
        sample_t cur;
        sample_t prev;
    } state_t;

    localparam strobe_t IDLE_ST = '{cs_n: 1'b1, wr_n: 1'b1, be_n: {LANES{1'b1}}};
    localparam sample_t IDLE_SMP = '{st: IDLE_ST, idx: '0, data: '0};

    state_t state_d, state_q;
    logic   unused_addr_hi;

    assign unused_addr_hi = ^addr;

    always_comb begin
        state_d          = state_q;
        state_d.prev     = state_q.cur;
        state_d.cur.st   = strobe_in;
        state_d.cur.idx  = addr[IDX_W-1:0];
        state_d.cur.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{cur: IDLE_SMP, prev: IDLE_SMP};
        end else begin
            state_q <= state_d;
        end
    end

    assign cur_st    = state_q.cur.st;
    assign prev_st   = state_q.prev.st;
    assign cur_idx   = state_q.cur.idx;
    assign prev_idx  = state_q.prev.idx;
    assign prev_data = state_q.prev.data;
endmodule

// File: rtl/lmr_write_tracker.sv
module lmr_write_tracker
    import lmr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  strobe_t           cur_st,
    input  strobe_t           prev_st,
    input  logic [IDX_W-1:0]  prev_idx,
    input  logic [DATA_W-1:0] prev_data,
    output logic              commit,
    output logic [LANES-1:0]  commit_mask,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [DATA_W-1:0] commit_data
);
    typedef struct packed {
        logic              armed;
        logic              fire;
        logic [LANES-1:0]  mask;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t state_d, state_q;
    logic   strobe_rise;
    logic   entered;

    always_comb begin
        strobe_rise = (cur_st.cs_n && !prev_st.cs_n)
                    || (cur_st.wr_n && !prev_st.wr_n)
                    || ((cur_st.be_n & ~prev_st.be_n) != '0);
        entered     = is_write(cur_st) && !is_write(prev_st);

        state_d      = state_q;
        state_d.fire = 1'b0;
        if (state_q.armed) begin
            if (strobe_rise) begin
                state_d.armed = 1'b0;
                state_d.fire  = 1'b1;
                state_d.mask  = ~prev_st.be_n;
                state_d.idx   = prev_idx;
                state_d.data  = prev_data;
            end
        end else if (entered) begin
            state_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign commit      = state_q.fire;
    assign commit_mask = state_q.mask;
    assign commit_idx  = state_q.idx;
    assign commit_data = state_q.data;
endmodule

// File: rtl/lmr_lane_store.sv
module lmr_lane_store
    import lmr_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                bank[wr_idx] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank[rd_idx];
    end
endmodule

// File: rtl/lane_masked_ram.sv
module lane_masked_ram
    import lmr_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              lo_en_n,
    input  logic              hi_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dq_o,
    output logic [LANES-1:0]  dq_oe
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  oe;
    } out_t;

    strobe_t           strobe_in;
    strobe_t           cur_st, prev_st;
    logic [IDX_W-1:0]  cur_idx, prev_idx, commit_idx;
    logic [DATA_W-1:0] prev_data, commit_data, rd_data;
    logic              commit;
    logic [LANES-1:0]  commit_mask;
    out_t              out_d, out_q;

    assign strobe_in = '{cs_n: cs_n, wr_n: wr_n, be_n: {hi_en_n, lo_en_n}};

    lmr_sampler #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (strobe_in),
        .addr      (addr),
        .din       (din),
        .cur_st    (cur_st),
        .prev_st   (prev_st),
        .cur_idx   (cur_idx),
        .prev_idx  (prev_idx),
        .prev_data (prev_data)
    );

    lmr_write_tracker #(.IDX_W(IDX_W)) i_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_st      (cur_st),
        .prev_st     (prev_st),
        .prev_idx    (prev_idx),
        .prev_data   (prev_data),
        .commit      (commit),
        .commit_mask (commit_mask),
        .commit_idx  (commit_idx),
        .commit_data (commit_data)
    );

    lmr_lane_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_store (
        .clk     (clk),
        .wr_en   (commit),
        .wr_mask (commit_mask),
        .wr_idx  (commit_idx),
        .wr_data (commit_data),
        .rd_idx  (cur_idx),
        .rd_data (rd_data)
    );

    always_comb begin
        out_d      = out_q;
        out_d.data = rd_data;
        for (int g = 0; g < LANES; g++) begin
            out_d.oe[g] = is_read(cur_st) && !cur_st.be_n[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dq_o  = out_q.data;
    assign dq_oe = out_q.oe;
endmodule

// File: rtl/lmr_checker.sv
module lmr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wr_n,
    input logic       lo_en_n,
    input logic       hi_en_n,
    input logic [1:0] dq_oe,
    input logic       commit,
    input logic [1:0] commit_mask
);
    AST_LO_LANE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe[0] |-> ($past(!cs_n, 2) && $past(wr_n, 2) && $past(!lo_en_n, 2))); // R3

    AST_HI_LANE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe[1] |-> ($past(!cs_n, 2) && $past(wr_n, 2) && $past(!hi_en_n, 2))); // R3

    AST_IDLE_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lo_en_n, 2) && $past(hi_en_n, 2)) |-> (dq_oe == 2'b00)); // R4

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n, 2) |-> (dq_oe == 2'b00)); // R6

    AST_WRITE_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wr_n, 2) |-> (dq_oe == 2'b00)); // R10

    AST_COMMIT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R8

    AST_COMMIT_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (commit_mask != 2'b00)); // R5
endmodule

bind lane_masked_ram lmr_checker i_lmr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .wr_n        (wr_n),
    .lo_en_n     (lo_en_n),
    .hi_en_n     (hi_en_n),
    .dq_oe       (dq_oe),
    .commit      (commit),
    .commit_mask (commit_mask)
);

// File: tb/test_lane_masked_ram.sv
module test_lane_masked_ram;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = 6;
    localparam int SPAN   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              wr_n = 1'b1;
    logic              lo_en_n = 1'b1;
    logic              hi_en_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       din = '0;
    logic [15:0]       dq_o;
    logic [1:0]        dq_oe;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] model [DEPTH];

    always #2.5 clk = ~clk;

    lane_masked_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_lane_masked_ram (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .lo_en_n(lo_en_n), .hi_en_n(hi_en_n), .addr(addr), .din(din),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int a, input int k);
        return 16'(a * 16'h1F3 + k * 16'h0B1 + 16'h5A3C);
    endfunction

    task automatic idle(input int n);
        cs_n = 1'b1; wr_n = 1'b1; lo_en_n = 1'b1; hi_en_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // mode 0: chip select rises first, 1: write strobe, 2: enabled lanes together,
    // 3: low lane first while high lane stays low
    task automatic wr(input int a, input logic [15:0] d, input logic lo, input logic hi, input int mode);
        addr = ADDR_W'(a); din = d;
        cs_n = 1'b0; wr_n = 1'b0; lo_en_n = !lo; hi_en_n = !hi;
        repeat (4) @(negedge clk);
        chk("R10 no drive in write", {14'd0, dq_oe}, 16'd0);
        case (mode)
            0: cs_n = 1'b1;
            1: wr_n = 1'b1;
            2: begin lo_en_n = 1'b1; hi_en_n = 1'b1; end
            default: lo_en_n = 1'b1;
        endcase
        @(negedge clk);
        din  = ~d;
        addr = ADDR_W'(a + 1);
        repeat (3) @(negedge clk);
        idle(3);
        if (lo) model[a % DEPTH][7:0]  = d[7:0];
        if (hi) model[a % DEPTH][15:8] = d[15:8];
    endtask

    task automatic rd(input int a, input logic lo, input logic hi, input string req);
        logic [15:0] w;
        addr = ADDR_W'(a);
        cs_n = 1'b0; wr_n = 1'b1; lo_en_n = !lo; hi_en_n = !hi;
        repeat (3) @(negedge clk);
        w = model[a % DEPTH];
        chk({req, " lanes"}, {14'd0, dq_oe}, {14'd0, hi, lo});
        if (lo) chk({req, " low byte"}, {8'd0, dq_o[7:0]}, {8'd0, w[7:0]});
        if (hi) chk({req, " high byte"}, {8'd0, dq_o[15:8]}, {8'd0, w[15:8]});
        idle(2);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset lanes", {14'd0, dq_oe}, 16'd0);
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {14'd0, dq_oe}, 16'd0);

        // R7 R9: full address sweep, aliases overwrite, end of cycle rotates
        for (int a = 0; a < SPAN; a++) wr(a, pat(a, 0), 1'b1, 1'b1, a % 3);
        for (int a = 0; a < SPAN; a++) rd(a, 1'b1, 1'b1, "R9 R2 wrap read");

        // R5 R8: every lane combination on every word
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < DEPTH; i++) begin
                wr(i + DEPTH * (m % 4), pat(i, m + 1), m[0], m[1], (m == 3) ? (i % 4) : (i % 3));
            end
            for (int i = 0; i < DEPTH; i++) rd(i, 1'b1, 1'b1, (m == 3) ? "R8 staggered" : "R5 lane mask");
        end

        // R3: single-lane reads
        for (int i = 0; i < DEPTH; i++) begin
            rd(i, 1'b1, 1'b0, "R3 low only");
            rd(i, 1'b0, 1'b1, "R3 high only");
        end

        // R4: selected, no lanes enabled, read and write
        addr = 6'd5; cs_n = 1'b0; wr_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 read no lanes", {14'd0, dq_oe}, 16'd0);
        idle(2);
        wr(5, 16'hDEAD, 1'b0, 1'b0, 0);
        rd(5, 1'b1, 1'b1, "R4 word kept");

        // R6: deselected write attempt
        addr = 6'd7; din = 16'hBEEF; cs_n = 1'b1; wr_n = 1'b0; lo_en_n = 1'b0; hi_en_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 no drive deselected", {14'd0, dq_oe}, 16'd0);
        wr_n = 1'b1; lo_en_n = 1'b1;
        repeat (3) @(negedge clk);
        idle(3);
        rd(7, 1'b1, 1'b1, "R6 word kept");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule